// File: doc/BRIEF.md
# RTC Status Read Synchronizer

This block connects a slow real-time-clock core to the faster bus clock domain. The RTC clock arrives as plain data. It passes through a short flop chain clocked by the bus clock. A rising edge seen at the end of that chain triggers one refresh. The refresh copies the core's count and divider values into bus-domain shadow registers, and it samples the core's three event lines.

Four sticky status bits are kept on the bus side:
- a second tick bit, set by the core's tick event;
- an alarm bit, set by the alarm event;
- a counter-wrap bit, set by the wrap event;
- a refresh-seen bit, set by every refresh.

Hardware sets these bits. Software clears them by writing zeros. Software reads the refresh-seen bit to learn when the shadows hold a valid copy after a bus-side reset. Three interrupt lines combine the event bits with per-source enable bits.

Top module: `rtc_status_sync`

## Requirements
- R1: While `rst` is high and after its release, `shd_cnt`, `shd_div`, `flags`, `ien` and `irq` are all zero until the first refresh or write.
- R2: A rising edge of `rtc_clk` that is first sampled at bus edge k makes the shadows take the values of `core_cnt` and `core_div` at bus edge k+2 (latency SYNC_STAGES+1 = 3 edges). The shadows keep their value at every other edge.
- R3: A falling edge of `rtc_clk` causes no refresh. Shadows and flags do not change when the core values change while `rtc_clk` is low.
- R4: `flags[3]` (refresh-seen) is set on every refresh. It stays 0 after reset until the first refresh.
- R5: On a refresh, `flags[0]`, `flags[1]` and `flags[2]` are set when `core_sec_evt`, `core_alr_evt` and `core_ovf_evt` respectively are high. An event line that is low leaves its bit unchanged.
- R6: A strobe on `flag_wr` clears each flag bit whose `flag_wdata` bit is 0. Bits written 1 are unchanged, so a write of 1 never sets a flag.
- R7: When a refresh sets a flag and a software clear targets that flag at the same bus edge, the flag ends set.
- R8: A strobe on `ien_wr` loads `ien` from `ien_wdata`. Bit 2 enables wrap, bit 1 enables alarm and bit 0 enables second.
- R9: `irq[i]` is high exactly when `flags[i]` and `ien[i]` are both 1, for i = 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high bus-side reset |
| rtc_clk | input | 1 | RTC core clock, sampled as data |
| core_cnt | input | CNT_W | Core counter value |
| core_div | input | DIV_W | Core divider value |
| core_sec_evt | input | 1 | Core second-tick event level |
| core_alr_evt | input | 1 | Core alarm event level |
| core_ovf_evt | input | 1 | Core counter-wrap event level |
| flag_wr | input | 1 | Flag clear strobe |
| flag_wdata | input | 4 | Clear mask (0 clears): bit3 refresh-seen, bit2 wrap, bit1 alarm, bit0 second |
| ien_wr | input | 1 | Enable write strobe |
| ien_wdata | input | 3 | New enables: bit2 wrap, bit1 alarm, bit0 second |
| shd_cnt | output | CNT_W | Shadow of the counter |
| shd_div | output | DIV_W | Shadow of the divider |
| flags | output | 4 | Sticky flags, same layout as `flag_wdata` |
| ien | output | 3 | Interrupt enables |
| irq | output | 3 | Interrupt requests, same layout as `ien` |

## Verification
Two operations can fall on the same bus edge: the hardware flag set at a refresh and the software clear. The bench provokes this by placing the `flag_wr` strobe on the exact cycle of the refresh, which it derives by counting bus edges from the point where it drives `rtc_clk` high. It judges the result against the rule "clear the old value, then OR in the set bits". It also sweeps every event pattern, every clear mask and every enable pattern, and checks that the shadows do not move one edge before the refresh or during the low phase of `rtc_clk`.

// File: rtl/rtc_rsync_pkg.sv
package rtc_rsync_pkg;

    localparam int FLG_SEC  = 0;
    localparam int FLG_ALR  = 1;
    localparam int FLG_OVF  = 2;
    localparam int FLG_SYNC = 3;
    localparam int FLG_N    = 4;
    localparam int IRQ_N    = 3;

    typedef struct packed {
        logic sync;
        logic ovf;
        logic alr;
        logic sec;
    } flag_t;

    // clear-by-zero first, then hardware set wins
    function automatic flag_t flag_next(flag_t cur, logic wr,
                                        logic [FLG_N-1:0] wdata, flag_t set);
        logic [FLG_N-1:0] v;
        v = cur;
        if (wr) v = v & wdata;
        return flag_t'(v | set);
    endfunction

endpackage

// File: rtl/rsync_edge.sv
module rsync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], async_in};
    end

    assign rise_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    // R3: a detected edge lasts one bus cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rsync_shadow.sv
module rsync_shadow #(
    parameter int CNT_W = 32,
    parameter int DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] core_cnt,
    input  logic [DIV_W-1:0] core_div,
    output logic [CNT_W-1:0] shd_cnt,
    output logic [DIV_W-1:0] shd_div
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cnt <= '0;
            shd_div <= '0;
        end else if (load) begin
            shd_cnt <= core_cnt;
            shd_div <= core_div;
        end
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(shd_cnt) && $stable(shd_div)));
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (shd_cnt == $past(core_cnt) && shd_div == $past(core_div)));
endmodule

// File: rtl/rsync_flags.sv
module rsync_flags
    import rtc_rsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             sec_evt,
    input  logic             alr_evt,
    input  logic             ovf_evt,
    input  logic             flag_wr,
    input  logic [FLG_N-1:0] flag_wdata,
    input  logic             ien_wr,
    input  logic [IRQ_N-1:0] ien_wdata,
    output flag_t            flags_q,
    output logic [IRQ_N-1:0] ien_q
);
    flag_t set_v;

    always_comb begin
        set_v      = '0;
        set_v.sync = load;
        set_v.sec  = load & sec_evt;
        set_v.alr  = load & alr_evt;
        set_v.ovf  = load & ovf_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            ien_q   <= '0;
        end else begin
            flags_q <= flag_next(flags_q, flag_wr, flag_wdata, set_v);
            if (ien_wr) ien_q <= ien_wdata;
        end
    end

    a_r4_sync_on_load: assert property (@(posedge clk) disable iff (rst)
        load |=> flags_q.sync);
    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (load && sec_evt && flag_wr && !flag_wdata[FLG_SEC]) |=> flags_q.sec);
    a_r6_no_set_without_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((flags_q & ~$past(flags_q)) == '0));
    a_r8_enable_load: assert property (@(posedge clk) disable iff (rst)
        ien_wr |=> (ien_q == $past(ien_wdata)));
endmodule

// File: rtl/rtc_status_sync.sv
module rtc_status_sync
    import rtc_rsync_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DIV_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rtc_clk,
    input  logic [CNT_W-1:0] core_cnt,
    input  logic [DIV_W-1:0] core_div,
    input  logic             core_sec_evt,
    input  logic             core_alr_evt,
    input  logic             core_ovf_evt,
    input  logic             flag_wr,
    input  logic [3:0]       flag_wdata,
    input  logic             ien_wr,
    input  logic [2:0]       ien_wdata,
    output logic [CNT_W-1:0] shd_cnt,
    output logic [DIV_W-1:0] shd_div,
    output logic [3:0]       flags,
    output logic [2:0]       ien,
    output logic [2:0]       irq
);
    logic  refresh;
    flag_t flg;

    rsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (rtc_clk),
        .rise_o   (refresh)
    );

    rsync_shadow #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (refresh),
        .core_cnt (core_cnt),
        .core_div (core_div),
        .shd_cnt  (shd_cnt),
        .shd_div  (shd_div)
    );

    rsync_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .load       (refresh),
        .sec_evt    (core_sec_evt),
        .alr_evt    (core_alr_evt),
        .ovf_evt    (core_ovf_evt),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .ien_wr     (ien_wr),
        .ien_wdata  (ien_wdata),
        .flags_q    (flg),
        .ien_q      (ien)
    );

    assign flags = flg;
    assign irq   = flags[IRQ_N-1:0] & ien;

    // R1: outputs zero in the cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (flags == '0 && ien == '0 && shd_cnt == '0));
endmodule

// File: tb/rtc_status_sync_tb.sv
module rtc_status_sync_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 32;
    localparam int DIV_W = 20;

    logic clk = 0;
    logic rst = 1;
    logic rtc_clk = 0;
    logic [CNT_W-1:0] core_cnt = '0;
    logic [DIV_W-1:0] core_div = '0;
    logic core_sec_evt = 0, core_alr_evt = 0, core_ovf_evt = 0;
    logic flag_wr = 0;
    logic [3:0] flag_wdata = '0;
    logic ien_wr = 0;
    logic [2:0] ien_wdata = '0;
    logic [CNT_W-1:0] shd_cnt;
    logic [DIV_W-1:0] shd_div;
    logic [3:0] flags;
    logic [2:0] ien, irq;

    int total = 0, bad = 0;
    logic [CNT_W-1:0] e_cnt = '0;
    logic [DIV_W-1:0] e_div = '0;
    logic [3:0] e_flags = '0;
    logic [2:0] e_ien = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_status_sync u_dut (
        .clk(clk), .rst(rst), .rtc_clk(rtc_clk),
        .core_cnt(core_cnt), .core_div(core_div),
        .core_sec_evt(core_sec_evt), .core_alr_evt(core_alr_evt),
        .core_ovf_evt(core_ovf_evt),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .shd_cnt(shd_cnt), .shd_div(shd_div),
        .flags(flags), .ien(ien), .irq(irq)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " cnt"}, 64'(shd_cnt), 64'(e_cnt));
        chk({req, " div"}, 64'(shd_div), 64'(e_div));
        chk({req, " flags"}, 64'(flags), 64'(e_flags));
        chk({req, " ien"}, 64'(ien), 64'(e_ien));
        chk({req, " irq R9"}, 64'(irq), 64'(e_flags[2:0] & e_ien));
    endtask

    // one RTC period; optional software clear on the refresh edge
    task automatic rtc_tick(logic [CNT_W-1:0] c, logic [DIV_W-1:0] d,
                            logic [2:0] ev, logic clr, logic [3:0] mask);
        @(negedge clk);
        core_cnt = c; core_div = d;
        {core_ovf_evt, core_alr_evt, core_sec_evt} = ev;
        rtc_clk = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_all("R2 before refresh");
        if (clr) begin flag_wr = 1; flag_wdata = mask; end
        @(posedge clk);
        @(negedge clk);
        flag_wr = 0;
        e_cnt = c; e_div = d;
        if (clr) e_flags = e_flags & mask;
        e_flags = e_flags | {1'b1, ev};
        chk_all(clr ? "R7 R5 R4 refresh with clear" : "R2 R4 R5 refresh");
        repeat (2) @(negedge clk);
        rtc_clk = 0;
        core_cnt = ~c; core_div = ~d;
        {core_ovf_evt, core_alr_evt, core_sec_evt} = 3'b111;
        repeat (5) @(negedge clk);
        chk_all("R3 falling edge ignored");
    endtask

    task automatic flag_write(logic [3:0] m);
        @(negedge clk);
        flag_wr = 1; flag_wdata = m;
        @(negedge clk);
        flag_wr = 0;
        e_flags = e_flags & m;
        chk_all("R6 clear by zero");
    endtask

    task automatic ien_write(logic [2:0] v);
        @(negedge clk);
        ien_wr = 1; ien_wdata = v;
        @(negedge clk);
        ien_wr = 0;
        e_ien = v;
        chk_all("R8 R9 enable write");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 in reset");
        rst = 0;
        repeat (4) @(negedge clk);
        chk_all("R1 R4 after reset before refresh");

        for (int i = 0; i < 8; i++)
            rtc_tick(32'h1000_0000 + 32'(i * 7), 20'(i * 3 + 1), 3'(i), 0, 4'hF);
        flag_write(4'h0);

        for (int m = 0; m < 16; m++) begin
            rtc_tick(32'hFFFF_FFF0 + 32'(m), 20'h7FFFF - 20'(m), 3'b111, 0, 4'hF);
            flag_write(4'(m));
        end

        rtc_tick(32'd55, 20'd5, 3'b111, 0, 4'hF);
        for (int v = 0; v < 8; v++) ien_write(3'(v));
        for (int m = 0; m < 8; m++) flag_write(4'hF & ~(4'd1 << (m % 4)));

        rtc_tick(32'd77, 20'd9, 3'b101, 1, 4'h0);
        rtc_tick(32'd78, 20'd8, 3'b010, 1, 4'h6);
        rtc_tick(32'd79, 20'd7, 3'b000, 1, 4'h0);

        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        e_cnt = '0; e_div = '0; e_flags = '0; e_ien = '0;
        @(negedge clk);
        chk_all("R1 second reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule